// File: doc/BRIEF.md
# External Bus Bring-Up Sequencer

This block powers up an external parallel bus in a fixed order after a single start pulse. It first turns on the output drivers for the bus reset line and the bus clock line, with the clock stopped and reset still asserted. It then starts the clock and holds the bus in reset for a minimum time measured in microseconds. Next it releases reset, hands bus arbitration to the on-chip arbiter, and waits a short settle time. Only then does it raise a ready flag.

All delays are counted in cycles of the system clock. The cycle counts come from a clock-frequency parameter and are rounded up, so no delay is ever shorter than asked.

The controller has six states. `ST_IDLE` is the state after reset, with every line off. `ST_DRV_EN` lasts one cycle and has the drivers enabled. `ST_CLK_RUN` has the clock running and reset held. `ST_RELEASE` lasts one cycle with reset released. `ST_ARB_SETTLE` has the internal arbiter selected while the settle time runs. `ST_READY` means the sequence is done.

The transitions are:
- start in `ST_IDLE` goes to `ST_DRV_EN`.
- `ST_DRV_EN` goes to `ST_CLK_RUN` unconditionally.
- `ST_CLK_RUN` goes to `ST_RELEASE` when the hold timer expires.
- `ST_RELEASE` goes to `ST_ARB_SETTLE` unconditionally.
- `ST_ARB_SETTLE` goes to `ST_READY` when the settle timer expires.
- start in `ST_READY` goes to `ST_DRV_EN`.

Top module: `bus_bringup_seq`

## Requirements
- R1: After reset, and whenever `rst_n` is low, all six outputs are 0. This includes `bus_rst_n_o`, so the bus is held in reset. The block stays in this state until `start_i` is seen high at a clock edge.
- R2: At the first rising edge with `start_i` high, `rst_oe_o` and `clk_oe_o` go to 1 while `clk_run_o`, `bus_rst_n_o`, `arb_int_o` and `done_o` stay 0. This lasts exactly one cycle.
- R3: At the next edge `clk_run_o` goes to 1. `bus_rst_n_o` stays 0 for exactly HOLD_CYC cycles with the clock running. HOLD_CYC = ceil(CLK_HZ/1e6) * HOLD_US, which is 7500 with the defaults.
- R4: After the hold, `bus_rst_n_o` goes to 1 for one cycle while `arb_int_o` is still 0.
- R5: `arb_int_o` then goes to 1 (1 selects the internal arbiter). It is only ever 1 while `bus_rst_n_o` and `clk_run_o` are 1.
- R6: `done_o` rises after exactly SETTLE_CYC cycles with `arb_int_o` high. SETTLE_CYC = ceil(CLK_HZ/1e6) * SETTLE_US, which is 50 with the defaults.
- R7: Once `done_o` is 1, it and all the line outputs stay 1 until a new start or a reset.
- R8: A start pulse while the sequence is running (step 1, clock/hold, release or settle) is ignored. The output timeline is unchanged.
- R9: A start pulse while `done_o` is 1 restarts the sequence from the one-cycle driver-enable step. That step has `clk_run_o`, `bus_rst_n_o`, `arb_int_o` and `done_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Start request, sampled at rising edges |
| rst_oe_o | output | 1 | Output enable for the bus reset driver |
| clk_oe_o | output | 1 | Output enable for the bus clock driver |
| clk_run_o | output | 1 | Bus clock running |
| bus_rst_n_o | output | 1 | Active-low bus reset line |
| arb_int_o | output | 1 | 1 = internal arbiter selected |
| done_o | output | 1 | Bring-up sequence complete |

## Verification
A wrong state or a miscounted timer shows on the line outputs in the very cycle it occurs, because the outputs are a registered decode of the next state. An off-by-one in the hold or settle count moves the rising edge of `bus_rst_n_o` or `done_o` by one cycle. A start that is wrongly accepted mid-run drops `clk_run_o` in the next cycle. The bench therefore compares all six outputs in every cycle against a timeline built from the requirements, which catches each of these faults within one cycle.

// File: rtl/ebrs_pkg.sv
package ebrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_DRV_EN     = 3'd1,
        ST_CLK_RUN    = 3'd2,
        ST_RELEASE    = 3'd3,
        ST_ARB_SETTLE = 3'd4,
        ST_READY      = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic rst_oe;
        logic clk_oe;
        logic clk_run;
        logic bus_rst_n;
        logic arb_int;
        logic done;
    } line_set_t;

    // Cycles per microsecond, rounded up so a delay is never short.
    function automatic int unsigned cyc_per_us(input longint unsigned hz);
        longint unsigned c;
        c = (hz + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/ebrs_delay_timer.sv
module ebrs_delay_timer #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // After a load of a nonzero value, the counter steps down by one.
    p_timer_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ebrs_seq_fsm.sv
module ebrs_seq_fsm
    import ebrs_pkg::*;
#(
    parameter int unsigned HOLD_CYC   = 7500,
    parameter int unsigned SETTLE_CYC = 50,
    parameter int unsigned W          = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         tmr_zero_i,
    output seq_state_t   next_o,
    output logic         tmr_load_o,
    output logic [W-1:0] tmr_val_o
);
    seq_state_t state_q, state_d;

    localparam logic [W-1:0] HOLD_LD   = W'(HOLD_CYC - 1);
    localparam logic [W-1:0] SETTLE_LD = W'(SETTLE_CYC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_DRV_EN;
            end
            ST_DRV_EN: begin
                state_d    = ST_CLK_RUN;
                tmr_load_o = 1'b1;
                tmr_val_o  = HOLD_LD;
            end
            ST_CLK_RUN: begin
                if (tmr_zero_i) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                state_d    = ST_ARB_SETTLE;
                tmr_load_o = 1'b1;
                tmr_val_o  = SETTLE_LD;
            end
            ST_ARB_SETTLE: begin
                if (tmr_zero_i) state_d = ST_READY;
            end
            ST_READY: begin
                if (start_i) state_d = ST_DRV_EN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign next_o = state_d;

    // R8: a start during a running sequence never restarts it.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q inside {ST_DRV_EN, ST_CLK_RUN, ST_RELEASE, ST_ARB_SETTLE})
        |=> (state_q != ST_DRV_EN));

    // R2: driver-enable step lasts one cycle.
    p_drv_step_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRV_EN) |=> (state_q == ST_CLK_RUN));

endmodule

// File: rtl/ebrs_line_decode.sv
module ebrs_line_decode
    import ebrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t next_i,
    output line_set_t  lines_o
);
    line_set_t dec;

    always_comb begin
        dec = '0;
        unique case (next_i)
            ST_IDLE:       dec = '0;
            ST_DRV_EN:     dec = '{rst_oe: 1'b1, clk_oe: 1'b1, default: 1'b0};
            ST_CLK_RUN:    dec = '{rst_oe: 1'b1, clk_oe: 1'b1, clk_run: 1'b1, default: 1'b0};
            ST_RELEASE:    dec = '{arb_int: 1'b0, done: 1'b0, default: 1'b1};
            ST_ARB_SETTLE: dec = '{done: 1'b0, default: 1'b1};
            ST_READY:      dec = '1;
            default:       dec = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_o <= '0;
        else        lines_o <= dec;
    end

endmodule

// File: rtl/bus_bringup_seq.sv
module bus_bringup_seq
    import ebrs_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned     HOLD_US   = 150,
    parameter int unsigned     SETTLE_US = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic rst_oe_o,
    output logic clk_oe_o,
    output logic clk_run_o,
    output logic bus_rst_n_o,
    output logic arb_int_o,
    output logic done_o
);
    localparam int unsigned CPU        = cyc_per_us(CLK_HZ);
    localparam int unsigned HOLD_CYC   = CPU * HOLD_US;
    localparam int unsigned SETTLE_CYC = CPU * SETTLE_US;
    localparam int unsigned MAX_CYC    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int unsigned W          = $clog2(MAX_CYC + 1);

    seq_state_t   nxt;
    logic         tmr_load, tmr_zero;
    logic [W-1:0] tmr_val;
    line_set_t    lines;

    ebrs_seq_fsm #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC), .W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tmr_zero_i(tmr_zero),
        .next_o    (nxt),
        .tmr_load_o(tmr_load),
        .tmr_val_o (tmr_val)
    );

    ebrs_delay_timer #(.W(W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    ebrs_line_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (nxt),
        .lines_o(lines)
    );

    assign rst_oe_o    = lines.rst_oe;
    assign clk_oe_o    = lines.clk_oe;
    assign clk_run_o   = lines.clk_run;
    assign bus_rst_n_o = lines.bus_rst_n;
    assign arb_int_o   = lines.arb_int;
    assign done_o      = lines.done;

    // Window counters for the timing properties.
    int unsigned hold_seen, settle_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_seen   <= 0;
            settle_seen <= 0;
        end else begin
            if (clk_run_o && !bus_rst_n_o) hold_seen <= hold_seen + 1;
            else if (!clk_run_o)           hold_seen <= 0;
            if (arb_int_o && !done_o)      settle_seen <= settle_seen + 1;
            else if (!arb_int_o)           settle_seen <= 0;
        end
    end

    // R2: the clock never runs without both drivers enabled.
    p_clk_needs_drivers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_run_o |-> (rst_oe_o && clk_oe_o));

    // R3: reset released only after the full hold with clock running.
    p_hold_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_n_o) |-> (hold_seen == HOLD_CYC));

    // R5: internal arbiter only with reset released and clock running.
    p_arb_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_int_o |-> (bus_rst_n_o && clk_run_o));

    // R6: done only after the full settle time.
    p_settle_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (settle_seen == SETTLE_CYC));

    // R7: done holds without a new start.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

// File: tb/tb_bus_bringup_seq.sv
`timescale 1ns/1ps
module tb_bus_bringup_seq;

    localparam int HOLD   = 7500;
    localparam int SETTLE = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic rst_oe_o, clk_oe_o, clk_run_o, bus_rst_n_o, arb_int_o, done_o;

    always #10 clk = ~clk;

    bus_bringup_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rst_oe_o(rst_oe_o), .clk_oe_o(clk_oe_o), .clk_run_o(clk_run_o),
        .bus_rst_n_o(bus_rst_n_o), .arb_int_o(arb_int_o), .done_o(done_o)
    );

    // {rst_oe, clk_oe, clk_run, bus_rst_n, arb_int, done}
    localparam logic [5:0] V_IDLE  = 6'b000000;
    localparam logic [5:0] V_DRV   = 6'b110000;
    localparam logic [5:0] V_CLK   = 6'b111000;
    localparam logic [5:0] V_REL   = 6'b111100;
    localparam logic [5:0] V_ARB   = 6'b111110;
    localparam logic [5:0] V_READY = 6'b111111;

    logic [5:0] exp_q[$];
    string      tag_q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Driver: one cycle of stimulus plus the expected outputs after the next edge.
    task automatic step(input logic st, input logic rn, input logic [5:0] ev, input string tag);
        @(negedge clk);
        start_i = st;
        rst_n   = rn;
        exp_q.push_back(ev);
        tag_q.push_back(tag);
    endtask

    function automatic logic [5:0] at_time(input int t, output string tag);
        if (t == 0)                        begin tag = "R2"; return V_DRV;   end
        else if (t <= HOLD)                begin tag = "R3"; return V_CLK;   end
        else if (t == HOLD + 1)            begin tag = "R4"; return V_REL;   end
        else if (t <= HOLD + 1 + SETTLE)   begin tag = "R6"; return V_ARB;   end
        else                               begin tag = "R7"; return V_READY; end
    endfunction

    // Full run: start pulse at t=0, optional stray starts mid-run (R8).
    task automatic run_seq(input bit stray, input string first_tag);
        string tg;
        logic [5:0] ev;
        for (int t = 0; t <= HOLD + SETTLE + 6; t++) begin
            ev = at_time(t, tg);
            if (t == 0) tg = first_tag;
            if (stray && (t == 1 || t == 300 || t == HOLD + 1 || t == HOLD + 10))
                step(1'b1, 1'b1, ev, "R8");
            else
                step(t == 0, 1'b1, ev, tg);
        end
    endtask

    // Monitor: compare after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [5:0] got, ev;
            string tg;
            got = {rst_oe_o, clk_oe_o, clk_run_o, bus_rst_n_o, arb_int_o, done_o};
            ev = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (got !== ev) begin
                errors++;
                $display("FAIL %s at %0t: got %b expected %b", tg, $time, got, ev);
            end
        end
    end

    initial begin
        // R1: reset state, then idle without start.
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, V_IDLE, "R1");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, V_IDLE, "R1");
        // R2..R8: full run with stray starts that must be ignored.
        run_seq(1'b1, "R2");
        // R7: done holds.
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, V_READY, "R7");
        // R9: restart from done drops the clock again, then a clean run.
        run_seq(1'b0, "R9");
        // R1: reset in the middle of a run.
        run_seq_partial();
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, V_IDLE, "R1");
        // Third run after reset recovery.
        run_seq(1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic run_seq_partial();
        step(1'b1, 1'b1, V_DRV, "R9");
        for (int t = 1; t <= 200; t++) step(1'b0, 1'b1, V_CLK, "R3");
        step(1'b0, 1'b0, V_IDLE, "R1");
        step(1'b0, 1'b0, V_IDLE, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule